// File: doc/BRIEF.md
# Sixteen-Pin GPIO Port with Level Interrupt Request

A 16-pin general-purpose port with three software-visible registers: a direction register, an output latch whose read path returns live pin levels, and an interrupt enable register. Any pin that is an input and has its enable bit set becomes an interrupt source. The source is active-low and level-sensitive. All active sources are ORed into a single registered request line. There is no edge capture and no status register. A handler finds the requesting pins by reading the data register, and it clears the request by removing the low level at the pin or by masking the pin.

Every pin passes through a two-flop synchronizer. That synchronized level feeds both the read path and the request logic. A power-on reset clears all three registers. A manual reset clears only the synchronizers and the request flop, so the port configuration survives it.

Top module: `gpio16_lvlirq`

## Requirements
- R1: After power-on reset (`por_n` low), the direction, output latch and enable registers read 0, `pin_oe` is 0 and `irq_o` is 0.
- R2: Register addresses are 0 for direction (1 = output), 1 for data and 2 for interrupt enable. All 16 bits are writable and read back through `rdata`. Address 3 reads 0, and a write to it changes no register.
- R3: A read of address 1 returns, for each bit, the output latch value if the pin is an output, or the synchronized pin level if it is an input. A pin change is visible on the read path two rising edges after it occurs.
- R4: A pin that is an input, is enabled and is held low raises `irq_o` on the third rising edge after it goes low. `irq_o` stays high for as long as that pin stays low.
- R5: `irq_o` is the OR over all pins. A pin whose enable bit is 0 never contributes, whatever its level.
- R6: A pin whose direction bit is 1 never contributes to `irq_o`, even when it is enabled and the pin is low.
- R7: `irq_o` falls on the third rising edge after the last active pin returns high. It also falls on the first rising edge after a write that masks the last active pin.
- R8: Manual reset (`mrst_n` low) drops `irq_o` at once and leaves all three registers unchanged. After release, a pin that is still active raises `irq_o` again on the third rising edge.
- R9: A power-on reset asserted during operation returns every register to 0.
- R10: `pin_out` equals the output latch and `pin_oe` equals the direction register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| mrst_n | input | 1 | Manual reset, active low, asynchronous; keeps registers |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` (combinational) |
| pin_in | input | 16 | Pin levels from the pads |
| pin_out | output | 16 | Output latch driven to the pads |
| pin_oe | output | 16 | Per-pin output enable |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
A table of configurations pairs direction, enable and pin patterns with the expected read value and request level. It separates three cases: a pin that is low but masked, a pin that is low but configured as an output, and a pin that is low, enabled and an input. It also covers mixed-direction patterns, where the read path has to take half of its bits from the latch and half from the pins. Directed sequences then pin down the three-edge assertion and release latency and the one-edge drop after a mask write. A manual reset is shown to clear the request but not the configuration, while a power-on reset clears both.

// File: rtl/gpio16_lvlirq.sv
module gpio16_lvlirq #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic         mrst_n,
  input  logic         wr_en,
  input  logic [1:0]   addr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe,
  output logic         irq_o
);
  localparam logic [1:0] A_DIR = 2'd0;
  localparam logic [1:0] A_DAT = 2'd1;
  localparam logic [1:0] A_IEN = 2'd2;

  logic [W-1:0] dir_q, dout_q, ien_q;
  logic [W-1:0] sync1, sync2;
  logic [W-1:0] active;
  logic         irq_q;
  logic         live_n;

  assign live_n = por_n & mrst_n;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      dir_q  <= '0;
      dout_q <= '0;
      ien_q  <= '0;
    end else if (wr_en) begin
      case (addr)
        A_DIR:   dir_q  <= wdata;
        A_DAT:   dout_q <= wdata;
        A_IEN:   ien_q  <= wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge live_n) begin
    if (!live_n) begin
      sync1 <= '1;
      sync2 <= '1;
      irq_q <= 1'b0;
    end else begin
      sync1 <= pin_in;
      sync2 <= sync1;
      irq_q <= |active;
    end
  end

  assign active  = ien_q & ~dir_q & ~sync2;
  assign pin_out = dout_q;
  assign pin_oe  = dir_q;
  assign irq_o   = irq_q;

  always_comb begin
    case (addr)
      A_DIR:   rdata = dir_q;
      A_DAT:   rdata = (dir_q & dout_q) | (~dir_q & sync2);
      A_IEN:   rdata = ien_q;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio16_lvlirq_chk.sv
module gpio16_lvlirq_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         por_n,
  input logic         mrst_n,
  input logic         wr_en,
  input logic [1:0]   addr,
  input logic [W-1:0] wdata,
  input logic [W-1:0] dir_q,
  input logic [W-1:0] ien_q,
  input logic [W-1:0] sync2,
  input logic         irq_o
);
  p_wr_dir_r2: assert property (@(posedge clk) disable iff (!por_n)
    (wr_en && addr == 2'd0) |=> dir_q == $past(wdata));

  p_ien_hold_r8: assert property (@(posedge clk) disable iff (!por_n)
    !(wr_en && addr == 2'd2) |=> $stable(ien_q));

  p_irq_rise_r4: assert property (@(posedge clk) disable iff (!por_n || !mrst_n)
    (|(ien_q & ~dir_q & ~sync2)) |=> irq_o);

  p_irq_masked_r5: assert property (@(posedge clk) disable iff (!por_n)
    (ien_q == '0) |=> !irq_o);

  p_out_quiet_r6: assert property (@(posedge clk) disable iff (!por_n)
    (&dir_q) |=> !irq_o);

  p_irq_drop_r7: assert property (@(posedge clk) disable iff (!por_n || !mrst_n)
    !(|(ien_q & ~dir_q & ~sync2)) |=> !irq_o);
endmodule

bind gpio16_lvlirq gpio16_lvlirq_chk #(.W(W)) u_chk (
  .clk(clk), .por_n(por_n), .mrst_n(mrst_n), .wr_en(wr_en), .addr(addr),
  .wdata(wdata), .dir_q(dir_q), .ien_q(ien_q), .sync2(sync2), .irq_o(irq_o)
);

// File: tb/gpio16_lvlirq_test.sv
module gpio16_lvlirq_test;
  logic        clk = 0;
  logic        por_n = 0, mrst_n = 1, wr_en = 0;
  logic [1:0]  addr = 0;
  logic [15:0] wdata = 0, pin_in = 16'hFFFF;
  logic [15:0] rdata, pin_out, pin_oe;
  logic        irq_o;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  gpio16_lvlirq uut (
    .clk(clk), .por_n(por_n), .mrst_n(mrst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .irq_o(irq_o)
  );

  // {dir, dout, ien, pins, expected data read, expected irq}
  localparam logic [95:0] VEC [7] = '{
    {16'h0000, 16'h0000, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'h0000},
    {16'h0000, 16'h0000, 16'h0001, 16'hFFFE, 16'hFFFE, 16'h0001},
    {16'h0000, 16'h0000, 16'h0002, 16'hFFFE, 16'hFFFE, 16'h0000},
    {16'h0001, 16'h0000, 16'h0001, 16'hFFFE, 16'hFFFE, 16'h0000},
    {16'hFF00, 16'hA500, 16'h00FF, 16'h0F7F, 16'hA57F, 16'h0001},
    {16'hFF00, 16'h5A00, 16'hFF00, 16'h0000, 16'h5A00, 16'h0000},
    {16'h0000, 16'h0000, 16'h8000, 16'h7FFF, 16'h7FFF, 16'h0001}
  };

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [15:0] v;
    step(3);
    por_n = 1;
    step(1);
    // R1 reset state
    rd(2'd0, v); chk("R1 dir", v, 16'h0);
    rd(2'd2, v); chk("R1 ien", v, 16'h0);
    chk("R1 oe", pin_oe, 16'h0);
    chk("R1 irq", {15'b0, irq_o}, 16'h0);
    wr(2'd1, 16'h1234); wr(2'd1, 16'h0000);
    rd(2'd1, v); chk("R1 data", v, 16'hFFFF);

    for (int k = 0; k < 7; k++) begin
      wr(2'd0, VEC[k][95:80]);
      wr(2'd1, VEC[k][79:64]);
      wr(2'd2, VEC[k][63:48]);
      pin_in = VEC[k][47:32];
      step(4);
      rd(2'd1, v); chk($sformatf("R3 vec%0d data", k), v, VEC[k][31:16]);
      chk($sformatf("R5 R6 vec%0d irq", k), {15'b0, irq_o}, VEC[k][15:0]);
      chk($sformatf("R10 vec%0d oe", k), pin_oe, VEC[k][95:80]);
      chk($sformatf("R10 vec%0d out", k), pin_out, VEC[k][79:64]);
    end

    // R2: full-width readback and address 3
    wr(2'd0, 16'hA55A); rd(2'd0, v); chk("R2 dir rb", v, 16'hA55A);
    wr(2'd2, 16'h5AA5); rd(2'd2, v); chk("R2 ien rb", v, 16'h5AA5);
    wr(2'd3, 16'hFFFF);
    rd(2'd3, v); chk("R2 addr3", v, 16'h0);
    rd(2'd0, v); chk("R2 dir after addr3", v, 16'hA55A);
    rd(2'd2, v); chk("R2 ien after addr3", v, 16'h5AA5);

    // R4 / R3 latency
    wr(2'd0, 16'h0000); wr(2'd2, 16'h0001);
    pin_in = 16'hFFFF; step(4);
    pin_in = 16'hFFFE;
    step(1); chk("R4 edge1", {15'b0, irq_o}, 16'h0);
    rd(2'd1, v); chk("R3 edge1 data", v, 16'hFFFF);
    step(1); chk("R4 edge2", {15'b0, irq_o}, 16'h0);
    rd(2'd1, v); chk("R3 edge2 data", v, 16'hFFFE);
    step(1); chk("R4 edge3", {15'b0, irq_o}, 16'h1);
    step(5); chk("R4 held", {15'b0, irq_o}, 16'h1);

    // R7 release by pin
    pin_in = 16'hFFFF;
    step(2); chk("R7 pin edge2", {15'b0, irq_o}, 16'h1);
    step(1); chk("R7 pin edge3", {15'b0, irq_o}, 16'h0);

    // R7 release by mask
    pin_in = 16'hFFFE; step(4);
    chk("R7 pre-mask", {15'b0, irq_o}, 16'h1);
    wr(2'd2, 16'h0000);
    chk("R7 mask edge0", {15'b0, irq_o}, 16'h1);
    step(1); chk("R7 mask edge1", {15'b0, irq_o}, 16'h0);

    // R8 manual reset
    wr(2'd0, 16'h00F0); wr(2'd1, 16'h0030); wr(2'd2, 16'h0001);
    step(4); chk("R8 pre", {15'b0, irq_o}, 16'h1);
    @(negedge clk); mrst_n = 0; #1;
    chk("R8 drop", {15'b0, irq_o}, 16'h0);
    step(2); mrst_n = 1;
    rd(2'd0, v); chk("R8 dir kept", v, 16'h00F0);
    rd(2'd2, v); chk("R8 ien kept", v, 16'h0001);
    chk("R8 out kept", pin_out, 16'h0030);
    step(2); chk("R8 rel edge2", {15'b0, irq_o}, 16'h0);
    step(1); chk("R8 rel edge3", {15'b0, irq_o}, 16'h1);

    // R9 power-on reset mid-run
    @(negedge clk); por_n = 0; step(2); por_n = 1; step(1);
    rd(2'd0, v); chk("R9 dir", v, 16'h0);
    rd(2'd2, v); chk("R9 ien", v, 16'h0);
    chk("R9 out", pin_out, 16'h0);
    chk("R9 irq", {15'b0, irq_o}, 16'h0);

    done = 1;
    finish_run();
  end
endmodule